// File: doc/BRIEF.md
# Flash Write-Permission Gate

This block decides, for a serial flash device, whether each command decoded by the serial front end may take effect. The front end raises a one-cycle completion strobe with the opcode, the target address, a small status-write payload and a flag that says whether the command ended exactly on a byte boundary. The gate keeps the write-enable latch, the deep power-down state, the quad-command mode flag and the protection status bits. It answers each command it recognises with a one-cycle grant or a one-cycle reject.

Commands that change the array or the status are held back by several guards. A power-on lockout timer blocks them for a fixed number of cycles after reset. The write-enable latch must be set. The device must not be busy. The target must lie outside the read-only region chosen by the four protect bits. While deep power-down is active, the gate filters out everything except the three wake-capable commands. A low write-protect pin freezes the protect bits and the protect-lock bit, unless quad operation is enabled.

Top module: `wpg_top`

## Requirements
- R1: While reset is held and on the first cycle after release, grant_o, reject_o, wel_o, dpd_o, qpi_o, srp_o, qe_o are 0, bp_o is 0 and lock_o is 1.
- R2: A completed, byte-aligned write-enable command (opcode 0x06) is granted and sets wel_o. Write-disable (0x04) is granted and clears it.
- R3: The modifying commands are status write 0x01, page program 0x02, sector erase 0x20, 32 KB erase 0x52, block erase 0xD8, chip erase 0xC7 and security write 0x2F. One of them is granted only when wel_o is 1, busy is 0 and lock_o is 0. A granted one leaves wel_o at 0.
- R4: A rejected command pulses reject_o for exactly one cycle and leaves wel_o, dpd_o, qpi_o, bp_o, srp_o and qe_o unchanged.
- R5: A command presented with cmd_byte_ok at 0 produces neither grant nor reject and changes no state.
- R6: Enter power-down (0xB9) is granted and sets dpd_o. While dpd_o is 1, every opcode other than 0xAB, 0x90 and 0x99 produces no pulse and no state change. 0xAB and 0x90 are granted and clear dpd_o.
- R7: For protect value b = bp_o, b=0 protects nothing. Otherwise the top 2^(15+b) bytes of the 2^23-byte array are protected, capped at the whole array. Program and sector or block erase with an address in that region are rejected. Chip erase is rejected whenever bp_o is nonzero.
- R8: A granted status write takes cmd_wdata bit 5 as srp_o, bit 4 as qe_o and bits 3:0 as bp_o. When wp_n is 0 and both qe_o and qpi_o are 0, only qe_o is written and bp_o and srp_o keep their values.
- R9: lock_o stays 1 for LOCK_CYC cycles after reset release and 0 afterwards. While it is 1, every modifying command is rejected.
- R10: Suspend (0x75) is granted while busy is 1 and then clears wel_o. With busy at 0 it is rejected.
- R11: Soft reset (0x99) is granted and clears wel_o, dpd_o and qpi_o but keeps bp_o, srp_o and qe_o. Quad mode on (0x38) sets qpi_o and quad mode off (0xF5) clears it, both granted.
- R12: grant_o and reject_o are never 1 together. Opcodes outside the listed set produce neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command-complete strobe |
| cmd_byte_ok | input | 1 | Command ended on a byte boundary |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_wdata | input | 6 | Status-write payload |
| busy | input | 1 | Program or erase in progress |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| grant_o | output | 1 | Command accepted (one-cycle pulse) |
| reject_o | output | 1 | Command refused (one-cycle pulse) |
| wel_o | output | 1 | Write-enable latch |
| dpd_o | output | 1 | Deep power-down active |
| qpi_o | output | 1 | Quad-command mode active |
| bp_o | output | 4 | Block-protect value |
| srp_o | output | 1 | Status protect-lock bit |
| qe_o | output | 1 | Quad-enable bit |
| lock_o | output | 1 | Power-on lockout active |

## Verification
Modifying commands are issued with each guard failing on its own: inside the lockout window, with the latch clear, while busy, and at addresses on both sides of the protected boundary. Each rejection can therefore be tied to a single cause. Status writes are repeated with the pin high, the pin low, and the pin low with quad enabled, which separates the lock from ordinary field updates. Power-down is entered and left through each of the three permitted opcodes, with ordinary opcodes sent in between to show the filter. Misaligned and unknown opcodes are sent with the latch set, so any change they caused would show.

// File: rtl/wpg_pkg.sv
`timescale 1ns/1ps
package wpg_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_WREN, K_WRDI, K_WRSR, K_PROG, K_CHIP, K_SCUR,
    K_SUSP, K_SRST, K_DP, K_WAKE, K_QON, K_QOFF
  } cmd_kind_e;

  typedef struct packed {
    logic       srp;
    logic       qe;
    logic [3:0] bp;
  } stat_t;

  function automatic cmd_kind_e kind_of(input logic [7:0] op);
    case (op)
      8'h06: return K_WREN;
      8'h04: return K_WRDI;
      8'h01: return K_WRSR;
      8'h02, 8'h20, 8'h52, 8'hD8: return K_PROG;
      8'hC7: return K_CHIP;
      8'h2F: return K_SCUR;
      8'h75: return K_SUSP;
      8'h99: return K_SRST;
      8'hB9: return K_DP;
      8'hAB, 8'h90: return K_WAKE;
      8'h38: return K_QON;
      8'hF5: return K_QOFF;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic is_mod_kind(input cmd_kind_e k);
    return (k == K_WRSR) || (k == K_PROG) || (k == K_CHIP) || (k == K_SCUR);
  endfunction

  function automatic logic is_wake_op(input logic [7:0] op);
    return (op == 8'hAB) || (op == 8'h90) || (op == 8'h99);
  endfunction

  // Top-of-array region: size 2^(bs+bp-1), capped at 2^aw.
  function automatic logic in_locked_region(input logic [31:0] addr,
                                            input logic [3:0]  bp,
                                            input int unsigned aw,
                                            input int unsigned bs);
    int unsigned sh;
    logic [31:0] top;
    if (bp == 4'd0) return 1'b0;
    sh = bs + 32'(bp) - 1;
    if (sh >= aw) return 1'b1;
    top = (32'd1 << (aw - sh)) - 32'd1;
    return (addr >> sh) == top;
  endfunction

endpackage

// File: rtl/wpg_lockout.sv
`timescale 1ns/1ps
module wpg_lockout #(
  parameter int unsigned LOCK_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign lock_o = (cnt_q < CW'(LOCK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (lock_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LOCK_CYC));
  a_r9_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |=> !lock_o);
endmodule

// File: rtl/wpg_decide.sv
`timescale 1ns/1ps
module wpg_decide
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned BLK_SHIFT = 16
) (
  input  logic              cmd_valid,
  input  logic              cmd_byte_ok,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              busy,
  input  logic              wp_n,
  input  logic              wel,
  input  logic              dpd,
  input  logic              qpi,
  input  stat_t             stat,
  input  logic              lock,
  output logic              accept,
  output logic              refuse,
  output cmd_kind_e         kind,
  output logic              hw_lock
);
  logic live, fail, mod_block, region_hit;

  assign kind       = kind_of(cmd_op);
  assign live       = cmd_valid && cmd_byte_ok && (kind != K_NONE)
                      && (!dpd || is_wake_op(cmd_op));
  assign mod_block  = lock || !wel || busy;
  assign region_hit = in_locked_region(32'(cmd_addr), stat.bp, ADDR_W, BLK_SHIFT);
  assign hw_lock    = !wp_n && !stat.qe && !qpi;

  always_comb begin
    case (kind)
      K_WRSR, K_SCUR: fail = mod_block;
      K_PROG:         fail = mod_block || region_hit;
      K_CHIP:         fail = mod_block || (stat.bp != 4'd0);
      K_SUSP:         fail = !busy;
      default:        fail = 1'b0;
    endcase
  end

  assign accept = live && !fail;
  assign refuse = live && fail;
endmodule

// File: rtl/wpg_state.sv
`timescale 1ns/1ps
module wpg_state
  import wpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      refuse,
  input  cmd_kind_e kind,
  input  logic      hw_lock,
  input  logic [5:0] wdata,
  output logic      grant_q,
  output logic      reject_q,
  output logic      wel_q,
  output logic      dpd_q,
  output logic      qpi_q,
  output stat_t     stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
      wel_q    <= 1'b0;
      dpd_q    <= 1'b0;
      qpi_q    <= 1'b0;
      stat_q   <= '0;
    end else begin
      grant_q  <= accept;
      reject_q <= refuse;
      if (accept) begin
        case (kind)
          K_WREN: wel_q <= 1'b1;
          K_WRDI: wel_q <= 1'b0;
          K_WRSR: begin
            wel_q <= 1'b0;
            if (hw_lock) stat_q.qe <= wdata[4];
            else         stat_q    <= wdata;
          end
          K_PROG, K_CHIP, K_SCUR, K_SUSP: wel_q <= 1'b0;
          K_SRST: begin
            wel_q <= 1'b0;
            dpd_q <= 1'b0;
            qpi_q <= 1'b0;
          end
          K_DP:   dpd_q <= 1'b1;
          K_WAKE: dpd_q <= 1'b0;
          K_QON:  qpi_q <= 1'b1;
          K_QOFF: qpi_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_q && reject_q));
  a_r4_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (reject_q && $stable(wel_q) && $stable(dpd_q) && $stable(qpi_q)
                && $stable(stat_q)));
  a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_WREN) |=> wel_q);
  a_r3_mod_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_mod_kind(kind)) |=> !wel_q);
  a_r8_pin_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_WRSR && hw_lock) |=> ($stable(stat_q.bp) && $stable(stat_q.srp)));
endmodule

// File: rtl/wpg_top.sv
`timescale 1ns/1ps
module wpg_top
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned BLK_SHIFT = 16,
  parameter int unsigned LOCK_CYC  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_byte_ok,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [5:0]        cmd_wdata,
  input  logic              busy,
  input  logic              wp_n,
  output logic              grant_o,
  output logic              reject_o,
  output logic              wel_o,
  output logic              dpd_o,
  output logic              qpi_o,
  output logic [3:0]        bp_o,
  output logic              srp_o,
  output logic              qe_o,
  output logic              lock_o
);
  logic      lock, accept, refuse, hw_lock;
  logic      wel, dpd, qpi;
  cmd_kind_e kind;
  stat_t     stat;

  wpg_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_o(lock)
  );

  wpg_decide #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_dec (
    .cmd_valid(cmd_valid), .cmd_byte_ok(cmd_byte_ok), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .busy(busy), .wp_n(wp_n), .wel(wel), .dpd(dpd),
    .qpi(qpi), .stat(stat), .lock(lock), .accept(accept), .refuse(refuse),
    .kind(kind), .hw_lock(hw_lock)
  );

  wpg_state u_st (
    .clk(clk), .rst_n(rst_n), .accept(accept), .refuse(refuse), .kind(kind),
    .hw_lock(hw_lock), .wdata(cmd_wdata), .grant_q(grant_o), .reject_q(reject_o),
    .wel_q(wel), .dpd_q(dpd), .qpi_q(qpi), .stat_q(stat)
  );

  assign wel_o  = wel;
  assign dpd_o  = dpd;
  assign qpi_o  = qpi;
  assign bp_o   = stat.bp;
  assign srp_o  = stat.srp;
  assign qe_o   = stat.qe;
  assign lock_o = lock;

  a_r5_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_byte_ok) |=> (!grant_o && !reject_o && $stable(wel_o)
                                     && $stable(dpd_o) && $stable(bp_o)));
  a_r6_sleep_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dpd_o && !is_wake_op(cmd_op)) |=> (!grant_o && !reject_o && dpd_o));
  a_r3_latch_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_mod_kind(kind_of(cmd_op)) && !wel_o) |=> !grant_o);
  a_r9_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && lock_o && is_mod_kind(kind_of(cmd_op))) |=> !grant_o);
endmodule

// File: tb/tb_wpg_top.sv
`timescale 1ns/1ps
module tb_wpg_top;
  localparam int LOCK = 20;
  localparam int AW   = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_byte_ok = 0, busy = 0, wp_n = 1;
  logic [7:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [5:0] cmd_wdata = 0;
  logic grant_o, reject_o, wel_o, dpd_o, qpi_o, srp_o, qe_o, lock_o;
  logic [3:0] bp_o;

  always #4 clk = ~clk;

  wpg_top #(.ADDR_W(AW), .BLK_SHIFT(16), .LOCK_CYC(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte_ok(cmd_byte_ok),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .wp_n(wp_n), .grant_o(grant_o), .reject_o(reject_o), .wel_o(wel_o),
    .dpd_o(dpd_o), .qpi_o(qpi_o), .bp_o(bp_o), .srp_o(srp_o), .qe_o(qe_o),
    .lock_o(lock_o)
  );

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  bit cmp_en = 0, done = 0;

  // reference model state
  bit m_g, m_r, m_wel, m_dpd, m_qpi, m_srp, m_qe;
  int m_bp, m_up;

  function automatic bit prot(int a, int b);
    longint span;
    if (b == 0) return 0;
    span = 64'd1 << (15 + b);
    if (span >= (64'd1 << AW)) return 1;
    return longint'(a) >= ((64'd1 << AW) - span);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_g = 0; m_r = 0; m_wel = 0; m_dpd = 0; m_qpi = 0;
      m_srp = 0; m_qe = 0; m_bp = 0; m_up = 0;
    end else begin
      automatic bit lk = (m_up < LOCK);
      automatic bit bad;
      m_g = 0; m_r = 0;
      if (cmd_valid && cmd_byte_ok &&
          (!m_dpd || cmd_op == 8'hAB || cmd_op == 8'h90 || cmd_op == 8'h99)) begin
        case (cmd_op)
          8'h06: begin m_g = 1; m_wel = 1; end
          8'h04: begin m_g = 1; m_wel = 0; end
          8'h01, 8'h2F, 8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7: begin
            bad = lk || !m_wel || busy;
            if (cmd_op inside {8'h02, 8'h20, 8'h52, 8'hD8} && prot(int'(cmd_addr), m_bp)) bad = 1;
            if (cmd_op == 8'hC7 && m_bp != 0) bad = 1;
            if (bad) m_r = 1;
            else begin
              m_g = 1; m_wel = 0;
              if (cmd_op == 8'h01) begin
                if (!wp_n && !m_qe && !m_qpi) m_qe = cmd_wdata[4];
                else begin
                  m_srp = cmd_wdata[5]; m_qe = cmd_wdata[4]; m_bp = int'(cmd_wdata[3:0]);
                end
              end
            end
          end
          8'h75: if (busy) begin m_g = 1; m_wel = 0; end else m_r = 1;
          8'h99: begin m_g = 1; m_wel = 0; m_dpd = 0; m_qpi = 0; end
          8'hB9: begin m_g = 1; m_dpd = 1; end
          8'hAB, 8'h90: begin m_g = 1; m_dpd = 0; end
          8'h38: begin m_g = 1; m_qpi = 1; end
          8'hF5: begin m_g = 1; m_qpi = 0; end
          default: ;
        endcase
      end
      if (lk) m_up++;
    end
  end

  task automatic cmp(string nm, int act, int exp);
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      checks++;
      cmp("grant", grant_o, m_g);
      cmp("reject", reject_o, m_r);
      cmp("wel", wel_o, m_wel);
      cmp("dpd", dpd_o, m_dpd);
      cmp("qpi", qpi_o, m_qpi);
      cmp("bp", bp_o, m_bp);
      cmp("srp", srp_o, m_srp);
      cmp("qe", qe_o, m_qe);
      cmp("lock", lock_o, (m_up < LOCK));
    end
  end

  task automatic issue(logic [7:0] op, int addr = 0, int d = 0, bit ok = 1);
    cmd_op = op; cmd_addr = AW'(addr); cmd_wdata = 6'(d);
    cmd_byte_ok = ok; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_byte_ok = 0;
    @(negedge clk);
  endtask

  task automatic expect_bit(string nm, bit act, bit exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, nm, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (2) @(negedge clk);
    cmp_en = 1;
    expect_bit("reset wel", wel_o, 0);
    expect_bit("reset lock", lock_o, 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_bit("wel after release", wel_o, 0);
    // lockout window
    cur_req = "R9";
    issue(8'h06);
    issue(8'h02, 0);
    expect_bit("wel kept after lockout reject", wel_o, 1);
    repeat (LOCK + 2) @(negedge clk);
    expect_bit("lock open", lock_o, 0);
    cur_req = "R3";
    issue(8'h02, 0);
    expect_bit("wel cleared by program", wel_o, 0);
    issue(8'h20, 4096);
    cur_req = "R2";
    issue(8'h06); issue(8'h04);
    expect_bit("wrdi clears", wel_o, 0);
    cur_req = "R5";
    issue(8'h06, 0, 0, 0);
    expect_bit("misaligned wren ignored", wel_o, 0);
    issue(8'h06); issue(8'h04, 0, 0, 0);
    expect_bit("misaligned wrdi ignored", wel_o, 1);
    cur_req = "R4";
    busy = 1; issue(8'hD8, 0);
    expect_bit("busy reject keeps wel", wel_o, 1);
    cur_req = "R10";
    issue(8'h75); busy = 0;
    expect_bit("suspend clears wel", wel_o, 0);
    issue(8'h75);
    cur_req = "R8";
    issue(8'h06); issue(8'h01, 0, 6'h02);
    expect_bit("bp written", bp_o == 4'd2, 1);
    cur_req = "R7";
    issue(8'h06); issue(8'h02, 23'h7F0000);
    expect_bit("top region refused", wel_o, 1);
    issue(8'h52, 23'h7DFFFF);
    issue(8'h06); issue(8'hC7);
    issue(8'h06); issue(8'h02, 23'h7E0000);
    cur_req = "R8";
    wp_n = 0;
    issue(8'h06); issue(8'h01, 0, 6'h25);
    expect_bit("pin keeps bp", bp_o == 4'd2, 1);
    issue(8'h06); issue(8'h01, 0, 6'h10);
    expect_bit("qe written under pin", qe_o, 1);
    issue(8'h06); issue(8'h01, 0, 6'h20);
    expect_bit("srp written with qe set", srp_o, 1);
    wp_n = 1;
    issue(8'h06); issue(8'h01, 0, 6'h00);
    cur_req = "R6";
    issue(8'h06); issue(8'hB9);
    issue(8'h04); issue(8'h02, 0); issue(8'hB9); issue(8'h38);
    expect_bit("wel kept in sleep", wel_o, 1);
    issue(8'h90);
    expect_bit("signature wakes", dpd_o, 0);
    issue(8'hB9); issue(8'hAB);
    cur_req = "R11";
    issue(8'h38);
    expect_bit("quad on", qpi_o, 1);
    issue(8'hF5); issue(8'h38); issue(8'h06); issue(8'hB9); issue(8'h99);
    expect_bit("soft reset wakes", dpd_o, 0);
    expect_bit("soft reset clears quad", qpi_o, 0);
    cur_req = "R12";
    issue(8'h06); issue(8'h03); issue(8'hFF);
    expect_bit("unknown keeps wel", wel_o, 1);
    issue(8'h2F); issue(8'h06); issue(8'h52, 0); issue(8'h06); issue(8'hC7);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule